// File: doc/BRIEF.md
# Bulk DMA Word Engine with End-of-Transfer Detection

This block is the device-side DMA engine for bulk endpoints in a USB peripheral controller. It moves 16-bit words between an endpoint buffer and a host-side DMA requester. Every word uses a request/acknowledge handshake. While it runs, the engine keeps a running word address and a remaining byte count. It stops when one of three separately enabled conditions occurs:
- the programmed byte count is used up;
- a short packet ends the transfer;
- software clears the enable.

Software sets the direction, start address, byte count and stop-condition enables, then raises the enable. The engine requests the bus once per word and steps the address and count after each acknowledged word. For an OUT endpoint, the packet length and short flag come from the endpoint status inputs. For an IN endpoint, the engine tracks its own position within 64-byte packets. When the transfer ends, a one-clock interrupt pulse and a cause register report why. A software disable records its cause but raises no pulse.

Top module: `dmaEotEngine`

## Requirements
- R1: On a 0-to-1 change of `dmaEnable`, the engine loads `remain` from `progCount` and `wordAddr` from `startAddr`, and clears `eotCause` to 0.
- R2: Handshake. `busReq` is high while a word is pending. A word transfers on the clock where `busReq`, `busAck` and `dmaEnable` are all high. `busReq` is low in the cycle after a transfer, and it stays low until `busAck` has been seen low.
- R3: Each transferred word adds 2 to `wordAddr`. A two-byte word (`byteEn` = 2'b11, bit 0 low byte, bit 1 high byte) subtracts 2 from `remain`.
- R4: A word that carries one byte shows `byteEn` = 2'b01 and subtracts 1 from `remain`. A word carries one byte when the count is 1 or when one byte is left in the current packet. `remain` never wraps below 0.
- R5: With `cntEotEn` = 1, the word that brings `remain` to 0 ends the transfer with `eotCause` = 1 (count). Cause codes: 0 none, 1 count, 2 short packet, 3 disabled.
- R6: With `shortEotEn` = 1 and `dirIn` = 0, a packet flagged short (`pktShort`, `pktLen` ≥ 1 bytes) is transferred completely. The transfer then ends with `eotCause` = 2, which takes priority over a count end on the same word.
- R7: With `shortEotEn` = 1 and `dirIn` = 1, the transfer ends with `eotCause` = 2 when `remain` reaches 0 partway through a 64-byte packet. When `remain` reaches 0 exactly on a packet boundary, the short condition does not apply, and only a count end (cause 1) is possible.
- R8: Clearing `dmaEnable` while a transfer is active stops it on the next clock. `eotCause` becomes 3, `busReq` falls, and no interrupt pulse is raised.
- R9: `eotIrq` pulses high for exactly one clock when the transfer ends with cause 1 or 2.
- R10: After any end of transfer, `busReq` stays low and `busAck` has no effect on `remain` or `wordAddr`, until `dmaEnable` is cleared and set again.
- R11: If `progCount` is 0 and `cntEotEn` = 1 when the engine is enabled, it ends at once with cause 1 and an interrupt pulse, and never raises `busReq`.
- R12: After reset, `busReq`, `eotIrq`, `eotCause`, `remain` and `wordAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dmaEnable | input | 1 | DMA enable; its rising edge arms a transfer |
| cntEotEn | input | 1 | Enable end of transfer on count exhaustion |
| shortEotEn | input | 1 | Enable end of transfer on short packet |
| dirIn | input | 1 | Endpoint direction: 1 IN, 0 OUT |
| progCount | input | 16 | Programmed byte count |
| startAddr | input | 16 | Start address of the transfer |
| pktLen | input | 7 | Byte length of the current OUT packet |
| pktShort | input | 1 | Current OUT packet is short |
| busAck | input | 1 | Bus acknowledge from requester side |
| busReq | output | 1 | Bus request for one word |
| byteEn | output | 2 | Valid bytes of the current word |
| wordAddr | output | 16 | Current transfer address |
| remain | output | 16 | Remaining byte count |
| eotIrq | output | 1 | One-clock end-of-transfer interrupt |
| eotCause | output | 2 | Cause of the last end of transfer |

## Verification
The bench targets the following corner cases:
- **Odd counts and odd OUT packet lengths.** A design that wraps the counter or drops the one-byte enable would show a huge remainder or `byteEn` 2'b11 on the final word.
- **IN transfers ending mid-packet versus exactly on a 64-byte boundary.** Confusing the two reports the wrong cause.
- **Short OUT packets that end before the count does.** Here the short cause must win, and bytes must be left over in `remain`.
- **Holding `busAck` high after a word.** A design that re-requests too early would raise `busReq` while acknowledge is still asserted.
- **Disabling mid-transfer.** A design that raises an interrupt here, or that keeps requesting after any end, is caught by watching `eotIrq` and `busReq`.
- **A zero count.** A design that issues a request before ending on a zero count is caught the same way.

// File: rtl/dmaEotPkg.sv
package dmaEotPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_REL  = 2'd2
  } stateT;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_COUNT   = 2'd1,
    CAUSE_SHORT   = 2'd2,
    CAUSE_DISABLE = 2'd3
  } causeT;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  step;
    logic  setCause;
    causeT cause;
  } ctrlStrobeT;

  // condition flags from datapath to control
  typedef struct packed {
    logic loadZero;
    logic endShort;
    logic endCount;
  } pathFlagT;

endpackage

// File: rtl/dmaEotPath.sv
module dmaEotPath
  import dmaEotPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int PKT_W   = 7,
  parameter int MAX_PKT = 64,
  parameter int WORD_B  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic              cntEotEn,
  input  logic              shortEotEn,
  input  logic              dirIn,
  input  logic [CNT_W-1:0]  progCount,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [PKT_W-1:0]  pktLen,
  input  logic              pktShort,
  output pathFlagT          flags,
  output logic [1:0]        byteEn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [CNT_W-1:0]  remain,
  output logic [1:0]        eotCause
);

  localparam logic [PKT_W-1:0]  PKT_FULL  = PKT_W'(MAX_PKT);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_B);

  logic [CNT_W-1:0]  countQ;
  logic [ADDR_W-1:0] addrQ;
  logic [PKT_W-1:0]  posQ;
  causeT             causeQ;

  logic [PKT_W-1:0]  pktLimit;
  logic [PKT_W-1:0]  pktRemain;
  logic              oneByte;
  logic [1:0]        moved;
  logic [CNT_W-1:0]  countNext;
  logic [PKT_W-1:0]  posSum;
  logic              pktEnd;
  logic              shortOut;
  logic              shortIn;

  // per-word byte accounting
  always_comb begin
    pktLimit  = dirIn ? PKT_FULL : pktLen;
    pktRemain = pktLimit - posQ;
    oneByte   = (pktRemain == PKT_W'(1)) || (countQ == CNT_W'(1));
    moved     = oneByte ? 2'd1 : 2'd2;
    countNext = (countQ >= CNT_W'(moved)) ? (countQ - CNT_W'(moved)) : '0;
    posSum    = posQ + PKT_W'(moved);
    pktEnd    = (posSum >= pktLimit);
  end

  // termination conditions for the word now pending
  always_comb begin
    shortOut       = !dirIn && pktShort && pktEnd;
    shortIn        = dirIn && (countQ != '0) && (countNext == '0) && !pktEnd;
    flags.endShort = shortEotEn && (shortOut || shortIn);
    flags.endCount = cntEotEn && (countNext == '0);
    flags.loadZero = cntEotEn && (progCount == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      addrQ  <= '0;
      posQ   <= '0;
      causeQ <= CAUSE_NONE;
    end else begin
      if (strb.load) begin
        countQ <= progCount;
        addrQ  <= startAddr;
        posQ   <= '0;
        causeQ <= CAUSE_NONE;
      end else if (strb.step) begin
        countQ <= countNext;
        addrQ  <= addrQ + ADDR_STEP;
        posQ   <= pktEnd ? '0 : posSum;
      end
      if (strb.setCause) begin
        causeQ <= strb.cause;
      end
    end
  end

  assign byteEn   = oneByte ? 2'b01 : 2'b11;
  assign wordAddr = addrQ;
  assign remain   = countQ;
  assign eotCause = causeQ;

endmodule

// File: rtl/dmaEotCtrl.sv
module dmaEotCtrl
  import dmaEotPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaEnable,
  input  logic       busAck,
  input  pathFlagT   flags,
  output ctrlStrobeT strb,
  output logic       busReq,
  output logic       eotIrq
);

  stateT stateQ, stateN;
  logic  enPrevQ;
  logic  enRise;
  logic  irqN, irqQ;

  assign enRise = dmaEnable && !enPrevQ;

  always_comb begin
    stateN = stateQ;
    strb   = '0;
    irqN   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (enRise) begin
          strb.load = 1'b1;
          if (flags.loadZero) begin
            strb.setCause = 1'b1;
            strb.cause    = CAUSE_COUNT;
            irqN          = 1'b1;
          end else begin
            stateN = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (!dmaEnable) begin
          strb.setCause = 1'b1;
          strb.cause    = CAUSE_DISABLE;
          stateN        = ST_IDLE;
        end else if (busAck) begin
          strb.step = 1'b1;
          if (flags.endShort) begin
            strb.setCause = 1'b1;
            strb.cause    = CAUSE_SHORT;
            irqN          = 1'b1;
            stateN        = ST_IDLE;
          end else if (flags.endCount) begin
            strb.setCause = 1'b1;
            strb.cause    = CAUSE_COUNT;
            irqN          = 1'b1;
            stateN        = ST_IDLE;
          end else begin
            stateN = ST_REL;
          end
        end
      end
      ST_REL: begin
        if (!dmaEnable) begin
          strb.setCause = 1'b1;
          strb.cause    = CAUSE_DISABLE;
          stateN        = ST_IDLE;
        end else if (!busAck) begin
          stateN = ST_REQ;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      enPrevQ <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      stateQ  <= stateN;
      enPrevQ <= dmaEnable;
      irqQ    <= irqN;
    end
  end

  assign busReq = (stateQ == ST_REQ);
  assign eotIrq = irqQ;

endmodule

// File: rtl/dmaEotEngine.sv
module dmaEotEngine
  import dmaEotPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 16,
  parameter int PKT_W   = 7,
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaEnable,
  input  logic              cntEotEn,
  input  logic              shortEotEn,
  input  logic              dirIn,
  input  logic [CNT_W-1:0]  progCount,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [PKT_W-1:0]  pktLen,
  input  logic              pktShort,
  input  logic              busAck,
  output logic              busReq,
  output logic [1:0]        byteEn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [CNT_W-1:0]  remain,
  output logic              eotIrq,
  output logic [1:0]        eotCause
);

  ctrlStrobeT strb;
  pathFlagT   flags;

  dmaEotCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .dmaEnable (dmaEnable),
    .busAck    (busAck),
    .flags     (flags),
    .strb      (strb),
    .busReq    (busReq),
    .eotIrq    (eotIrq)
  );

  dmaEotPath #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .PKT_W   (PKT_W),
    .MAX_PKT (MAX_PKT),
    .WORD_B  (2)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cntEotEn   (cntEotEn),
    .shortEotEn (shortEotEn),
    .dirIn      (dirIn),
    .progCount  (progCount),
    .startAddr  (startAddr),
    .pktLen     (pktLen),
    .pktShort   (pktShort),
    .flags      (flags),
    .byteEn     (byteEn),
    .wordAddr   (wordAddr),
    .remain     (remain),
    .eotCause   (eotCause)
  );

endmodule

// File: rtl/dmaEotChk.sv
module dmaEotChk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaEnable,
  input logic              busAck,
  input logic              busReq,
  input logic [1:0]        byteEn,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [CNT_W-1:0]  remain,
  input logic              eotIrq,
  input logic [1:0]        eotCause
);

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && dmaEnable |=> !busReq); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && dmaEnable |=> wordAddr == $past(wordAddr) + ADDR_W'(2)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && dmaEnable && byteEn == 2'b11 |=> remain == $past(remain) - CNT_W'(2)); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && dmaEnable |=> remain <= $past(remain)); // R4

  AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |=> !busReq); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    eotIrq |-> (eotCause == 2'd1 || eotCause == 2'd2)); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    eotIrq |=> !eotIrq); // R9

  AST_IDLE_AFTER_EOT: assert property (@(posedge clk) disable iff (!rstN)
    eotIrq |-> !busReq); // R10

endmodule

bind dmaEotEngine dmaEotChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .dmaEnable (dmaEnable),
  .busAck    (busAck),
  .busReq    (busReq),
  .byteEn    (byteEn),
  .wordAddr  (wordAddr),
  .remain    (remain),
  .eotIrq    (eotIrq),
  .eotCause  (eotCause)
);

// File: tb/sim_dmaEotEngine.sv
`timescale 1ns/1ps
module sim_dmaEotEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dmaEnable = 1'b0;
  logic        cntEotEn = 1'b0;
  logic        shortEotEn = 1'b0;
  logic        dirIn = 1'b0;
  logic [15:0] progCount = '0;
  logic [15:0] startAddr = '0;
  logic [6:0]  pktLen = 7'd64;
  logic        pktShort = 1'b0;
  logic        busAck = 1'b0;
  logic        busReq;
  logic [1:0]  byteEn;
  logic [15:0] wordAddr;
  logic [15:0] remain;
  logic        eotIrq;
  logic [1:0]  eotCause;

  int testCount = 0;
  int failCount = 0;
  int irqSeen = 0;

  always #2 clk = ~clk;

  dmaEotEngine u0 (
    .clk(clk), .rstN(rstN), .dmaEnable(dmaEnable), .cntEotEn(cntEotEn),
    .shortEotEn(shortEotEn), .dirIn(dirIn), .progCount(progCount),
    .startAddr(startAddr), .pktLen(pktLen), .pktShort(pktShort),
    .busAck(busAck), .busReq(busReq), .byteEn(byteEn), .wordAddr(wordAddr),
    .remain(remain), .eotIrq(eotIrq), .eotCause(eotCause)
  );

  always @(negedge clk) if (rstN && eotIrq) irqSeen++;

  typedef struct packed {
    logic [15:0] cnt;
    logic        cntEn;
    logic        shortEn;
    logic        inDir;
    logic [6:0]  len;
    logic        isShort;
    logic [15:0] start;
    logic [7:0]  expWords;
    logic [1:0]  expCause;
    logic [1:0]  expBe;
    logic [15:0] expRemain;
    logic [15:0] expAddr;
  } vecT;

  localparam int NVEC = 8;
  localparam vecT VECS [NVEC] = '{
    '{16'd10,  1'b1, 1'b0, 1'b0, 7'd64, 1'b0, 16'h0100, 8'd5,  2'd1, 2'b11, 16'd0,   16'h010A},
    '{16'd7,   1'b1, 1'b0, 1'b1, 7'd64, 1'b0, 16'h0200, 8'd4,  2'd1, 2'b01, 16'd0,   16'h0208},
    '{16'd200, 1'b0, 1'b1, 1'b0, 7'd13, 1'b1, 16'h0000, 8'd7,  2'd2, 2'b01, 16'd187, 16'h000E},
    '{16'd100, 1'b1, 1'b1, 1'b1, 7'd64, 1'b0, 16'h0040, 8'd50, 2'd2, 2'b11, 16'd0,   16'h00A4},
    '{16'd128, 1'b1, 1'b1, 1'b1, 7'd64, 1'b0, 16'h0000, 8'd64, 2'd1, 2'b11, 16'd0,   16'h0080},
    '{16'd64,  1'b1, 1'b1, 1'b0, 7'd64, 1'b0, 16'h1000, 8'd32, 2'd1, 2'b11, 16'd0,   16'h1040},
    '{16'd5,   1'b1, 1'b1, 1'b0, 7'd4,  1'b1, 16'h0000, 8'd2,  2'd2, 2'b11, 16'd1,   16'h0004},
    '{16'd30,  1'b1, 1'b1, 1'b0, 7'd40, 1'b1, 16'h0000, 8'd15, 2'd1, 2'b11, 16'd0,   16'h001E}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  // one acknowledged word; returns after ack is released
  task automatic doWord(output logic [1:0] be);
    be = byteEn;
    busAck = 1'b1;
    @(negedge clk);
    busAck = 1'b0;
  endtask

  task automatic arm();
    dmaEnable = 1'b0;
    @(negedge clk);
    dmaEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic runVector(input vecT v, input int idx);
    int words = 0;
    int guard = 0;
    int irq0;
    logic [1:0] lastBe = 2'b00;
    logic [1:0] be;
    logic [15:0] keepRemain;
    logic [15:0] keepAddr;
    progCount  = v.cnt;
    cntEotEn   = v.cntEn;
    shortEotEn = v.shortEn;
    dirIn      = v.inDir;
    pktLen     = v.len;
    pktShort   = v.isShort;
    startAddr  = v.start;
    irq0 = irqSeen;
    arm();
    check("R1", $sformatf("vec%0d load remain", idx), remain, v.cnt);
    check("R1", $sformatf("vec%0d load cause", idx), eotCause, 0);
    while (guard < 1000) begin
      guard++;
      if (busReq) begin
        if (wordAddr != v.start + 16'(2 * words))
          check("R3", $sformatf("vec%0d addr word %0d", idx, words), wordAddr, v.start + 16'(2 * words));
        doWord(be);
        lastBe = be;
        words++;
        if (eotCause != 2'd0) break;
        if (busReq) check("R2", "request after word", busReq, 0);
      end
      @(negedge clk);
    end
    check("R5", $sformatf("vec%0d words", idx), words, v.expWords);
    check(v.expCause == 2'd2 ? (v.inDir ? "R7" : "R6") : "R5",
          $sformatf("vec%0d cause", idx), eotCause, v.expCause);
    check("R4", $sformatf("vec%0d last byteEn", idx), lastBe, v.expBe);
    check("R4", $sformatf("vec%0d remain", idx), remain, v.expRemain);
    check("R3", $sformatf("vec%0d end addr", idx), wordAddr, v.expAddr);
    @(negedge clk);
    check("R9", $sformatf("vec%0d irq pulses", idx), irqSeen - irq0, 1);
    // R10: idle, acknowledge ignored
    keepRemain = remain;
    keepAddr = wordAddr;
    busAck = 1'b1;
    repeat (3) @(negedge clk);
    busAck = 1'b0;
    @(negedge clk);
    check("R10", $sformatf("vec%0d idle req", idx), busReq, 0);
    check("R10", $sformatf("vec%0d idle remain", idx), remain, keepRemain);
    check("R10", $sformatf("vec%0d idle addr", idx), wordAddr, keepAddr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [1:0] be;
    int irq0;
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12", "reset busReq", busReq, 0);
    check("R12", "reset irq", eotIrq, 0);
    check("R12", "reset cause", eotCause, 0);
    check("R12", "reset remain", remain, 0);
    check("R12", "reset addr", wordAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) runVector(VECS[i], i);

    // R11 zero count
    progCount = 16'd0; cntEotEn = 1'b1; shortEotEn = 1'b0; dirIn = 1'b0;
    irq0 = irqSeen;
    arm();
    check("R11", "zero count irq", eotIrq, 1);
    check("R11", "zero count cause", eotCause, 1);
    check("R11", "zero count busReq", busReq, 0);
    @(negedge clk);
    check("R9", "irq one cycle", eotIrq, 0);
    repeat (3) @(negedge clk);
    check("R11", "zero count no request", busReq, 0);
    check("R9", "zero count pulses", irqSeen - irq0, 1);

    // R2 hold acknowledge, then R8 disable mid-transfer
    progCount = 16'd20; startAddr = 16'h0300; pktLen = 7'd64; pktShort = 1'b0;
    arm();
    check("R2", "request after arm", busReq, 1);
    busAck = 1'b1;
    @(negedge clk);
    check("R2", "drop after ack", busReq, 0);
    repeat (3) @(negedge clk);
    check("R2", "held ack no request", busReq, 0);
    busAck = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2", "request after release", busReq, 1);
    check("R3", "remain after one word", remain, 18);
    doWord(be); @(negedge clk);
    doWord(be); @(negedge clk);
    check("R3", "remain after three words", remain, 14);
    check("R3", "addr after three words", wordAddr, 16'h0306);
    irq0 = irqSeen;
    dmaEnable = 1'b0;
    @(negedge clk);
    check("R8", "disable cause", eotCause, 3);
    check("R8", "disable busReq", busReq, 0);
    busAck = 1'b1;
    repeat (2) @(negedge clk);
    busAck = 1'b0;
    @(negedge clk);
    check("R8", "disable no irq", irqSeen - irq0, 0);
    check("R8", "disable remain frozen", remain, 14);
    check("R10", "disable addr frozen", wordAddr, 16'h0306);
    dmaEnable = 1'b1;
    @(negedge clk);
    check("R1", "rearm cause cleared", eotCause, 0);
    check("R1", "rearm remain reload", remain, 20);
    check("R1", "rearm addr reload", wordAddr, 16'h0300);
    dmaEnable = 1'b0;
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule